// File: doc/BRIEF.md
# Prescaled Watchdog Reset Timer

This block guards a processor against running out of control. A free-running binary prescaler divides the oscillator clock. A small up counter advances once per period of one of two prescaler taps. Software must zero the counter with a clear strobe before it passes its top value. If software fails to do so, the counter wraps to zero and the block raises a reset request for one clock. The chip's reset logic then uses that request to restart the whole system.

A static option bit decides whether the watchdog exists at all. When the bit is low, the counter is held at zero and no reset request can ever be raised. A select bit picks the tap: the slow tap when set, the fast tap when clear. With the default parameters the fast tap divides by 2048 and the slow tap by 16384. A 4-bit counter therefore overflows after 16 tap periods, which is one second on a 32 kHz oscillator with the fast tap.

The counter logic is a three-state machine:
- Idle: entered from reset, and on any edge where the option bit is low.
- Counting: entered when the option bit is high, after a clear, after a plain step, or on an edge with no step.
- Bite: entered on the edge where a step moves the counter from its top value to zero. Bite always lasts one cycle. It then goes to Counting, or to Idle if the option bit is low.

The reset request is high only in the Bite state.

Top module: `wdt_prescaled`

## Requirements
- R1: While the async reset is active, and after its release, the counter reads 0 and the reset request is low.
- R2: With the enable option low, the counter stays at 0 and the reset request stays low, whatever the clear strobe and tap select do.
- R3: With tap select 0, a step occurs on the edge where the prescaler count, which is the number of edges since reset modulo 2^PRESC_STAGES, has the value 2^(TAP_FAST-1) modulo 2^TAP_FAST. The incremented counter is visible after that edge.
- R4: With tap select 1, the step occurs the same way using TAP_SLOW in place of TAP_FAST.
- R5: A clear strobe sampled at an edge zeroes the counter after that edge. It does not restart the prescaler, so later steps keep their phase.
- R6: When a clear and a step fall on the same edge, the counter reads 0 afterwards.
- R7: A step that moves the counter from 15 to 0 raises the reset request for exactly one cycle. That cycle is the first one in which the counter reads 0.
- R8: Changing the tap select does not alter the counter. The next step comes from the newly selected tap's own edge, with no spurious step caused by the switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wdt_en | input | 1 | Static enable option bit |
| tap_sel | input | 1 | 0 selects the fast tap, 1 selects the slow tap |
| wdt_clr | input | 1 | Software clear strobe |
| rst_req | output | 1 | One-cycle system reset request |
| count | output | CNT_W | Current watchdog counter value |

## Verification
The bench builds the block with a 4-stage prescaler, a fast tap of 2 and a slow tap of 4. A step then comes every 4 or 16 clocks, and each 4-bit overflow takes only 64 or 256 clocks. With these short periods, repeated wraps on both taps fit in a short run. The bench can also place a clear on every phase of the step, including the exact step edge, and switch taps at many offsets against both tap edges.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_COUNT = 2'd1,
        WD_BITE  = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int unsigned STAGES = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q + 1'b1;
    end
endmodule

// File: rtl/wdt_tap_pulse.sv
module wdt_tap_pulse #(
    parameter int unsigned STAGES   = 14,
    parameter int unsigned TAP_FAST = 11,
    parameter int unsigned TAP_SLOW = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAGES-1:0] q,
    input  logic              tap_sel,
    output logic              step
);
    localparam int unsigned NTAPS = 2;
    localparam int unsigned TAP_BIT [NTAPS] = '{TAP_FAST - 1, TAP_SLOW - 1};

    logic [NTAPS-1:0] prev;
    logic [NTAPS-1:0] rise;

    for (genvar i = 0; i < NTAPS; i++) begin : g_tap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev[i] <= 1'b0;
            else        prev[i] <= q[TAP_BIT[i]];
        end
        assign rise[i] = q[TAP_BIT[i]] & ~prev[i];
    end

    assign step = tap_sel ? rise[1] : rise[0];

    // R8: the two taps never rise together, so switching cannot merge edges
    p_taps_disjoint_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise[0] && rise[1]));
    // R3: a step is a single-cycle pulse
    p_step_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise[0] |=> !rise[0]);
endmodule

// File: rtl/wdt_counter_fsm.sv
module wdt_counter_fsm
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             rst_req
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    wd_state_e        state, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WD_IDLE;
            cnt_q <= '0;
        end else begin
            state <= state_n;
            cnt_q <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt_q;
        unique case (state)
            WD_IDLE, WD_COUNT, WD_BITE: begin
                if (!en) begin
                    state_n = WD_IDLE;
                    cnt_n   = '0;
                end else if (clr) begin
                    state_n = WD_COUNT;
                    cnt_n   = '0;
                end else if (step) begin
                    if (cnt_q == CNT_TOP) begin
                        state_n = WD_BITE;
                        cnt_n   = '0;
                    end else begin
                        state_n = WD_COUNT;
                        cnt_n   = cnt_q + 1'b1;
                    end
                end else begin
                    state_n = WD_COUNT;
                end
            end
            default: begin
                state_n = WD_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    always_comb begin
        count   = cnt_q;
        rst_req = (state == WD_BITE);
    end

    p_off_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (count == '0 && !rst_req));
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clr) |=> (count == '0));
    p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clr && step) |=> (count == '0 && !rst_req));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !step) |=> (count == $past(count)));
    p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && step && count == CNT_TOP) |=> (rst_req && count == '0));
endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled #(
    parameter int unsigned PRESC_STAGES = 14,
    parameter int unsigned TAP_FAST     = 11,
    parameter int unsigned TAP_SLOW     = 14,
    parameter int unsigned CNT_W        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_en,
    input  logic             tap_sel,
    input  logic             wdt_clr,
    output logic             rst_req,
    output logic [CNT_W-1:0] count
);
    logic [PRESC_STAGES-1:0] presc_q;
    logic                    step;

    wdt_prescaler #(.STAGES(PRESC_STAGES)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .q     (presc_q)
    );

    wdt_tap_pulse #(
        .STAGES   (PRESC_STAGES),
        .TAP_FAST (TAP_FAST),
        .TAP_SLOW (TAP_SLOW)
    ) u_tap (
        .clk     (clk),
        .rst_n   (rst_n),
        .q       (presc_q),
        .tap_sel (tap_sel),
        .step    (step)
    );

    wdt_counter_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (wdt_en),
        .clr     (wdt_clr),
        .step    (step),
        .count   (count),
        .rst_req (rst_req)
    );
endmodule

// File: tb/tb_wdt_prescaled.sv
module tb_wdt_prescaled;
    localparam int ST = 4;
    localparam int TF = 2;
    localparam int TS = 4;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          sel = 1'b0;
    logic          clr = 1'b0;
    logic          rq;
    logic [CW-1:0] cnt;

    int checks = 0;
    int fails  = 0;
    int mp     = 0;
    int mcnt   = 0;
    int mrq    = 0;

    wdt_prescaled #(
        .PRESC_STAGES (ST),
        .TAP_FAST     (TF),
        .TAP_SLOW     (TS),
        .CNT_W        (CW)
    ) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wdt_en  (en),
        .tap_sel (sel),
        .wdt_clr (clr),
        .rst_req (rq),
        .count   (cnt)
    );

    always #10 clk = ~clk;

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit will_step(int p, bit s);
        int k = s ? TS : TF;
        return (p % (1 << k)) == (1 << (k - 1));
    endfunction

    task automatic do_reset(bit e, bit s);
        @(negedge clk);
        rst_n = 1'b0;
        en  = e;
        sel = s;
        clr = 1'b0;
        #3;
        check("R1", "count", int'(cnt), 0);
        check("R1", "rst_req", int'(rq), 0);
        @(negedge clk);
        rst_n = 1'b1;
        mp = 0; mcnt = 0; mrq = 0;
        check("R1", "count", int'(cnt), 0);
        check("R1", "rst_req", int'(rq), 0);
    endtask

    task automatic tick(string tag);
        bit p;
        @(posedge clk);
        p = will_step(mp, sel);
        mrq = 0;
        if (!en) mcnt = 0;
        else if (clr) mcnt = 0;
        else if (p) begin
            if (mcnt == (1 << CW) - 1) begin
                mcnt = 0;
                mrq  = 1;
            end else begin
                mcnt = mcnt + 1;
            end
        end
        mp = (mp + 1) % (1 << ST);
        @(negedge clk);
        check(tag, "count", int'(cnt), mcnt);
        check(tag, "rst_req", int'(rq), mrq);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R2: disabled, with clears and tap changes
        do_reset(1'b0, 1'b0);
        for (int i = 0; i < 600; i++) begin
            clr = (i % 7 == 3);
            sel = (i % 50 < 25);
            tick("R2");
        end

        // R3 and R7: fast tap, several wraps
        do_reset(1'b1, 1'b0);
        for (int i = 0; i < 200; i++) tick("R3_R7");

        // R4 and R7: slow tap, two wraps
        do_reset(1'b1, 1'b1);
        for (int i = 0; i < 560; i++) tick("R4_R7");

        // R5: clears at every phase, prescaler keeps running
        for (int s = 0; s < 2; s++) begin
            do_reset(1'b1, s[0]);
            for (int i = 0; i < 700; i++) begin
                clr = (i % 37 == 36) || (i % 53 == 0);
                tick("R5");
            end
            clr = 1'b0;
        end

        // R6: clear exactly on step edges, then near wrap
        for (int s = 0; s < 2; s++) begin
            do_reset(1'b1, s[0]);
            for (int i = 0; i < 400; i++) begin
                clr = (mcnt >= 13) && will_step(mp, sel);
                tick("R6");
            end
            clr = 1'b0;
        end

        // R8: tap switching at many offsets
        do_reset(1'b1, 1'b0);
        for (int i = 0; i < 1500; i++) begin
            if (i % 13 == 5 || i % 29 == 11) sel = ~sel;
            tick("R8");
        end

        summary();
    end
endmodule